// File: doc/BRIEF.md
# SD Card Native-Bus Initialization Sequencer

This block takes a freshly powered SD card through the identification procedure on the one-bit native bus and leaves it in the transfer state. It builds each 48-bit command frame, including the CRC7 checksum, and shifts it out on the command line. Every command is preceded by a run of idle clocks with the line held high. After a command that expects a reply, the block listens for the card's start bit and captures the response.

The sequence is fixed. A software reset comes first, followed by an interface-condition probe. Next an application-command prefix and an operating-condition request are repeated until the card reports that power-up is complete. The block then reads the identification register and obtains the relative address, selects the card, and sets a 512-byte block length. If the interface probe gets no reply, the card is marked as a first-generation card. The capacity class is taken from the last operating-condition reply.

Once the block-length command has been acknowledged, `ready` rises and stays high until reset. The three unused data lines are held high throughout, so the card cannot drop into its serial-peripheral mode. The block runs on the card clock, and the board combines `cmd_out` and `cmd_oe` into the bidirectional command pin.

Top module: `sdnative_init_seq`

## Requirements
- R1: Commands are issued in the order index 0, 8, then the pair 55/41 one or more times, then 2, 3, 7, 16, and no others.
- R2: Arguments: index 0, 55, 2 and 3 carry 0x00000000; index 8 carries 0x000001AA; index 41 carries 0xC0100000; index 16 carries 0x00000200.
- R3: The index-7 argument holds the relative card address in bits [31:16] and zero in bits [15:0].
- R4: Before each command the line is driven high for an exact precount of clocks. The precount is LONG_PRE_SIM (128) or LONG_PRE_HW (64000, chosen by SIMULATE) before index 0 and index 16, and SHORT_PRE (48) before every other command.
- R5: Each frame is 48 bits sent MSB first: start 0, transmission 1, a 6-bit index, a 32-bit argument, CRC7 (x^7+x^3+1, zero seed) over those first 40 bits, and end bit 1.
- R6: The 55/41 pair is repeated while bit 31 of the 32-bit argument field of the index-41 response (frame bits [39:8]) is 0. The block moves on to index 2 only when that bit is 1.
- R7: `high_cap` equals bit 30 of the argument of the last index-41 response.
- R8: `card_v1` is set when no start bit arrives within RSP_WINDOW (64) clocks after the index-8 frame ends. Otherwise it stays 0.
- R9: `rca` takes bits [31:16] of the index-3 response argument.
- R10: `ready` is low until the rising edge after the one that samples the last bit of the index-16 response. It is high from then on.
- R11: `dat_high` is 3'b111 at all times.
- R12: During reset, `ready`, `high_cap`, `card_v1` and `rca` are zero and `cmd_oe` is low.
- R13: `cmd_oe` stays low while a response is being received. The index-2 response is 136 bits long, and all other responses are 48 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; all logic on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_in | input | 1 | Sampled level of the command line |
| cmd_out | output | 1 | Value to drive on the command line |
| cmd_oe | output | 1 | Command line output enable |
| dat_high | output | 3 | Levels for data lines 1 to 3, held high |
| ready | output | 1 | Card reached transfer state with 512-byte blocks |
| high_cap | output | 1 | Card is high capacity |
| card_v1 | output | 1 | Card ignored the interface-condition probe |
| rca | output | 16 | Relative card address |

## Verification
A command bit appears on `cmd_out` one clock after its predecessor. The precount is the exact number of clocks that `cmd_oe` is high with the line high before the start bit. The modelled card samples the line on falling edges, counts that run, and compares each completed frame against the next entry in the expected-command queue. A reply is driven starting two falling edges after the end bit, which lands inside the listening window that the block opens one clock after the frame ends. `ready` is checked low on the first falling edge after the final response bit and high on the second, matching its single register stage behind the response capture.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    localparam int CMD_FRAME_W = 48;
    localparam int RSP_SHORT_W = 48;
    localparam int RSP_LONG_W  = 136;

    typedef enum logic [3:0] {
        ST_RST,
        ST_IFCOND,
        ST_APPCMD,
        ST_OPCOND,
        ST_GETCID,
        ST_GETRCA,
        ST_SELECT,
        ST_BLKLEN,
        ST_DONE
    } step_e;

    typedef enum logic [1:0] {
        PH_ISSUE,
        PH_TX,
        PH_RX
    } phase_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_PRE,
        TX_SEND
    } tx_st_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_WAIT,
        RX_CAP
    } rx_st_e;

    typedef struct packed {
        step_e       step;
        phase_e      ph;
        logic [15:0] rca;
        logic        hc;
        logic        v1;
        logic        ready;
    } ctl_t;

    function automatic logic [5:0] step_index(input step_e s);
        case (s)
            ST_IFCOND: return 6'd8;
            ST_APPCMD: return 6'd55;
            ST_OPCOND: return 6'd41;
            ST_GETCID: return 6'd2;
            ST_GETRCA: return 6'd3;
            ST_SELECT: return 6'd7;
            ST_BLKLEN: return 6'd16;
            default:   return 6'd0;
        endcase
    endfunction

    function automatic logic step_long_pre(input step_e s);
        return (s == ST_RST) || (s == ST_BLKLEN);
    endfunction

endpackage

// File: rtl/sdinit_crc7.sv
module sdinit_crc7 #(
    parameter int DATA_W = 40
) (
    input  logic [DATA_W-1:0] data,
    output logic [6:0]        crc
);
    always_comb begin
        logic [6:0] acc;
        logic       fb;
        acc = 7'd0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = data[i] ^ acc[6];
            acc = {acc[5:0], 1'b0};
            if (fb) begin
                acc = acc ^ 7'b0001001;
            end
        end
        crc = acc;
    end
endmodule

// File: rtl/sdinit_cmd_tx.sv
module sdinit_cmd_tx
    import sdinit_pkg::*;
#(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [5:0]       idx,
    input  logic [31:0]      arg,
    input  logic [PRE_W-1:0] pre,
    output logic             cmd_out,
    output logic             cmd_oe,
    output logic             done
);
    typedef struct packed {
        tx_st_e                 st;
        logic [PRE_W-1:0]       cnt;
        logic [5:0]             bcnt;
        logic [CMD_FRAME_W-1:0] sh;
        logic                   done;
    } tx_t;

    localparam tx_t TX_RESET = '{st: TX_IDLE, cnt: '0, bcnt: '0, sh: '1, done: 1'b0};

    tx_t        q, d;
    logic [6:0] crc;

    sdinit_crc7 #(.DATA_W(40)) u_crc (
        .data ({2'b01, idx, arg}),
        .crc  (crc)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            TX_IDLE: begin
                if (start) begin
                    d.sh   = {2'b01, idx, arg, crc, 1'b1};
                    d.cnt  = pre;
                    d.bcnt = 6'd0;
                    d.st   = (pre == PRE_W'(0)) ? TX_SEND : TX_PRE;
                end
            end
            TX_PRE: begin
                d.cnt = q.cnt - PRE_W'(1);
                if (q.cnt == PRE_W'(1)) begin
                    d.st = TX_SEND;
                end
            end
            TX_SEND: begin
                d.sh   = {q.sh[CMD_FRAME_W-2:0], 1'b1};
                d.bcnt = q.bcnt + 6'd1;
                if (q.bcnt == 6'(CMD_FRAME_W - 1)) begin
                    d.st   = TX_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TX_RESET;
        else        q <= d;
    end

    assign cmd_oe  = (q.st != TX_IDLE);
    assign cmd_out = (q.st == TX_SEND) ? q.sh[CMD_FRAME_W-1] : 1'b1;
    assign done    = q.done;

    AST_PRE_ENDS_IN_START: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_PRE && q.cnt == PRE_W'(1)) |=> (cmd_oe && !cmd_out)); // R4
    AST_TX_BIT_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_SEND && q.bcnt == 6'd0) |=> cmd_out); // R5
    AST_END_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_SEND && q.bcnt == 6'(CMD_FRAME_W - 1)) |-> cmd_out); // R5
endmodule

// File: rtl/sdinit_rsp_rx.sv
module sdinit_rsp_rx
    import sdinit_pkg::*;
#(
    parameter int RSP_WINDOW = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic        long_rsp,
    input  logic        cmd_in,
    output logic        done,
    output logic        timeout,
    output logic        busy,
    output logic [15:0] arg_hi
);
    localparam int WIN_W = $clog2(RSP_WINDOW + 1);

    typedef struct packed {
        rx_st_e           st;
        logic             long_f;
        logic [WIN_W-1:0] wcnt;
        logic [7:0]       bcnt;
        logic [39:0]      sh;
        logic             done;
        logic             tmo;
    } rx_t;

    localparam rx_t RX_RESET = '{st: RX_IDLE, long_f: 1'b0, wcnt: '0, bcnt: '0,
                                 sh: '0, done: 1'b0, tmo: 1'b0};

    rx_t        q, d;
    logic [7:0] last_bit;

    assign last_bit = q.long_f ? 8'(RSP_LONG_W - 1) : 8'(RSP_SHORT_W - 1);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            RX_IDLE: begin
                if (arm) begin
                    d.st     = RX_WAIT;
                    d.long_f = long_rsp;
                    d.wcnt   = '0;
                end
            end
            RX_WAIT: begin
                if (!cmd_in) begin
                    d.st   = RX_CAP;
                    d.sh   = '0;
                    d.bcnt = 8'd1;
                end else if (q.wcnt == WIN_W'(RSP_WINDOW - 1)) begin
                    d.st   = RX_IDLE;
                    d.done = 1'b1;
                    d.tmo  = 1'b1;
                end else begin
                    d.wcnt = q.wcnt + WIN_W'(1);
                end
            end
            RX_CAP: begin
                d.sh   = {q.sh[38:0], cmd_in};
                d.bcnt = q.bcnt + 8'd1;
                if (q.bcnt == last_bit) begin
                    d.st   = RX_IDLE;
                    d.done = 1'b1;
                    d.tmo  = 1'b0;
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RX_RESET;
        else        q <= d;
    end

    assign done    = q.done;
    assign timeout = q.tmo;
    assign busy    = (q.st != RX_IDLE);
    assign arg_hi  = q.sh[39:24];

    AST_SILENT_WINDOW_TIMES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_WAIT && q.wcnt == WIN_W'(RSP_WINDOW - 1) && cmd_in) |=> (done && timeout)); // R8
    AST_CAPTURE_NOT_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(q.st == RX_CAP)) |-> !timeout); // R13
endmodule

// File: rtl/sdnative_init_seq.sv
module sdnative_init_seq
    import sdinit_pkg::*;
#(
    parameter bit SIMULATE     = 1'b0,
    parameter int LONG_PRE_HW  = 64000,
    parameter int LONG_PRE_SIM = 128,
    parameter int SHORT_PRE    = 48,
    parameter int RSP_WINDOW   = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_in,
    output logic        cmd_out,
    output logic        cmd_oe,
    output logic [2:0]  dat_high,
    output logic        ready,
    output logic        high_cap,
    output logic        card_v1,
    output logic [15:0] rca
);
    localparam int LONG_PRE = SIMULATE ? LONG_PRE_SIM : LONG_PRE_HW;
    localparam int MAX_PRE  = (LONG_PRE > SHORT_PRE) ? LONG_PRE : SHORT_PRE;
    localparam int PRE_W    = $clog2(MAX_PRE + 1);

    localparam ctl_t CTL_RESET = '{step: ST_RST, ph: PH_ISSUE, rca: '0,
                                   hc: 1'b0, v1: 1'b0, ready: 1'b0};

    ctl_t             q, d;
    logic             tx_start, tx_done;
    logic [5:0]       tx_idx;
    logic [31:0]      tx_arg;
    logic [PRE_W-1:0] tx_pre;
    logic             rx_arm, rx_long, rx_done, rx_timeout, rx_busy;
    logic [15:0]      rx_arg_hi;

    sdinit_cmd_tx #(.PRE_W(PRE_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tx_start),
        .idx     (tx_idx),
        .arg     (tx_arg),
        .pre     (tx_pre),
        .cmd_out (cmd_out),
        .cmd_oe  (cmd_oe),
        .done    (tx_done)
    );

    sdinit_rsp_rx #(.RSP_WINDOW(RSP_WINDOW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (rx_arm),
        .long_rsp (rx_long),
        .cmd_in   (cmd_in),
        .done     (rx_done),
        .timeout  (rx_timeout),
        .busy     (rx_busy),
        .arg_hi   (rx_arg_hi)
    );

    always_comb begin
        tx_idx  = step_index(q.step);
        tx_pre  = step_long_pre(q.step) ? PRE_W'(LONG_PRE) : PRE_W'(SHORT_PRE);
        rx_long = (q.step == ST_GETCID);
        case (q.step)
            ST_IFCOND: tx_arg = 32'h0000_01AA;
            ST_OPCOND: tx_arg = 32'hC010_0000;
            ST_SELECT: tx_arg = {q.rca, 16'h0000};
            ST_BLKLEN: tx_arg = 32'h0000_0200;
            default:   tx_arg = 32'h0000_0000;
        endcase
    end

    always_comb begin
        d        = q;
        tx_start = 1'b0;
        rx_arm   = 1'b0;
        case (q.ph)
            PH_ISSUE: begin
                if (q.step != ST_DONE) begin
                    tx_start = 1'b1;
                    d.ph     = PH_TX;
                end
            end
            PH_TX: begin
                if (tx_done) begin
                    if (q.step == ST_RST) begin
                        d.step = ST_IFCOND;
                        d.ph   = PH_ISSUE;
                    end else begin
                        rx_arm = 1'b1;
                        d.ph   = PH_RX;
                    end
                end
            end
            PH_RX: begin
                if (rx_done) begin
                    d.ph = PH_ISSUE;
                    case (q.step)
                        ST_IFCOND: begin
                            if (rx_timeout) d.v1 = 1'b1;
                            d.step = ST_APPCMD;
                        end
                        ST_APPCMD: begin
                            if (!rx_timeout) d.step = ST_OPCOND;
                        end
                        ST_OPCOND: begin
                            if (rx_timeout) begin
                                d.step = ST_APPCMD;
                            end else begin
                                d.hc   = rx_arg_hi[14];
                                d.step = rx_arg_hi[15] ? ST_GETCID : ST_APPCMD;
                            end
                        end
                        ST_GETCID: begin
                            if (!rx_timeout) d.step = ST_GETRCA;
                        end
                        ST_GETRCA: begin
                            if (!rx_timeout) begin
                                d.rca  = rx_arg_hi;
                                d.step = ST_SELECT;
                            end
                        end
                        ST_SELECT: begin
                            if (!rx_timeout) d.step = ST_BLKLEN;
                        end
                        ST_BLKLEN: begin
                            if (!rx_timeout) begin
                                d.ready = 1'b1;
                                d.step  = ST_DONE;
                            end
                        end
                        default: d.step = q.step;
                    endcase
                end
            end
            default: d.ph = PH_ISSUE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RESET;
        else        q <= d;
    end

    assign dat_high = 3'b111;
    assign ready    = q.ready;
    assign high_cap = q.hc;
    assign card_v1  = q.v1;
    assign rca      = q.rca;

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R10
    AST_READY_NEEDS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(rx_done && !rx_timeout)); // R10
    AST_OPCOND_BUSY_LOOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.step == ST_OPCOND && rx_done && !rx_timeout && !rx_arg_hi[15]) |=> (q.step == ST_APPCMD)); // R6
    AST_NO_DRIVE_WHILE_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> !rx_busy); // R13
    AST_RCA_FROM_ADDR_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rca) |-> $past(q.step == ST_GETRCA && rx_done)); // R9
endmodule

// File: tb/tb_sdnative_init_seq.sv
`timescale 1ns/1ps
module tb_sdnative_init_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe, ready, high_cap, card_v1;
    logic [2:0]  dat_high;
    logic [15:0] rca;

    int n_checks = 0;
    int n_err    = 0;

    typedef struct { logic [5:0] idx; logic [31:0] arg; } exp_t;
    exp_t exp_q[$];

    int          busy_rounds;
    logic        cfg_hc, cfg_v1;
    logic [15:0] cfg_rca;

    always #2.5 clk = ~clk;

    sdnative_init_seq #(.SIMULATE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .cmd_out(cmd_out),
        .cmd_oe(cmd_oe), .dat_high(dat_high), .ready(ready),
        .high_cap(high_cap), .card_v1(card_v1), .rca(rca)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [39:0] m);
        logic [6:0] r;
        r = 7'd0;
        for (int i = 39; i >= 0; i--) begin
            logic top;
            top = m[i] ^ r[6];
            r   = {r[5:0], 1'b0} ^ (top ? 7'h09 : 7'h00);
        end
        return r;
    endfunction

    task automatic push(input logic [5:0] i, input logic [31:0] a);
        exp_t e;
        e.idx = i;
        e.arg = a;
        exp_q.push_back(e);
    endtask

    // driver: expected command stream for the configured card (R1, R2, R3)
    task automatic drive_expected();
        push(6'd0, 32'h0);
        push(6'd8, 32'h1AA);
        for (int r = 0; r <= busy_rounds; r++) begin
            push(6'd55, 32'h0);
            push(6'd41, 32'hC010_0000);
        end
        push(6'd2, 32'h0);
        push(6'd3, 32'h0);
        push(6'd7, {cfg_rca, 16'h0});
        push(6'd16, 32'h200);
    endtask

    task automatic get_cmd(output logic [47:0] fr, output int pre);
        int run = 0;
        forever begin
            @(negedge clk);
            if (cmd_oe && cmd_out) run++;
            else if (cmd_oe && !cmd_out) break;
            else run = 0;
        end
        fr[47] = 1'b0;
        for (int i = 46; i >= 0; i--) begin
            @(negedge clk);
            fr[i] = cmd_out;
        end
        pre = run;
    endtask

    task automatic send_rsp(input logic [135:0] bits, input int len, input bit last);
        bit drove = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = len - 1; i >= 0; i--) begin
            if (i != len - 1) @(negedge clk);
            if (cmd_oe) drove = 1'b1;
            cmd_in = bits[i];
        end
        @(negedge clk);
        cmd_in = 1'b1;
        chk(!drove && !cmd_oe, "R13", "line driven during reply", 64'(drove), 64'd0);
        if (last) begin
            chk(ready == 1'b0, "R10", "ready one edge after last bit", 64'(ready), 64'd0);
            @(negedge clk);
            chk(ready == 1'b1, "R10", "ready two edges after last bit", 64'(ready), 64'd1);
        end
    endtask

    function automatic logic [47:0] short_rsp(input logic [5:0] i, input logic [31:0] a);
        return {2'b00, i, a, ref_crc({2'b00, i, a}), 1'b1};
    endfunction

    // monitor: pops expected commands, compares, plays the card's replies
    task automatic serve_card();
        int acmd_n = 0;
        while (exp_q.size() > 0) begin
            logic [47:0] fr;
            int          pre;
            exp_t        e;
            int          exp_pre;
            get_cmd(fr, pre);
            e = exp_q.pop_front();
            chk(fr[45:40] == e.idx, "R1", "command index", 64'(fr[45:40]), 64'(e.idx));
            if (e.idx == 6'd7)
                chk(fr[39:8] == e.arg, "R3", "select argument", 64'(fr[39:8]), 64'(e.arg));
            else
                chk(fr[39:8] == e.arg, "R2", "command argument", 64'(fr[39:8]), 64'(e.arg));
            chk(fr[46] == 1'b1 && fr[0] == 1'b1 && fr[7:1] == ref_crc(fr[47:8]),
                "R5", "frame bits/crc7", 64'(fr[7:0]), 64'({ref_crc(fr[47:8]), 1'b1}));
            exp_pre = (e.idx == 6'd0 || e.idx == 6'd16) ? 128 : 48;
            chk(pre == exp_pre, "R4", "precount", 64'(pre), 64'(exp_pre));
            chk(dat_high == 3'b111 && ready == 1'b0, "R11", "dat lines high, not ready",
                64'({dat_high, ready}), 64'(4'b1110));
            case (fr[45:40])
                6'd8:  if (!cfg_v1) send_rsp(136'(short_rsp(6'd8, 32'h1AA)), 48, 1'b0);
                6'd55: send_rsp(136'(short_rsp(6'd55, 32'h120)), 48, 1'b0);
                6'd41: begin
                    logic fin;
                    fin = (acmd_n == busy_rounds);
                    send_rsp(136'({2'b00, 6'h3F, fin, fin ? cfg_hc : ~cfg_hc, 30'h00FF_8000,
                                   7'h7F, 1'b1}), 48, 1'b0);
                    acmd_n++;
                end
                6'd2:  send_rsp({2'b00, 6'h3F, {15{8'h5A}}, 7'h11, 1'b1}, 136, 1'b0);
                6'd3:  send_rsp(136'(short_rsp(6'd3, {cfg_rca, 16'h0500})), 48, 1'b0);
                6'd7:  send_rsp(136'(short_rsp(6'd7, 32'h700)), 48, 1'b0);
                6'd16: send_rsp(136'(short_rsp(6'd16, 32'h900)), 48, 1'b1);
                default: ;
            endcase
        end
        // R6: exactly busy_rounds+1 operating-condition requests were answered
        chk(acmd_n == busy_rounds + 1, "R6", "op-cond rounds", 64'(acmd_n), 64'(busy_rounds + 1));
    endtask

    task automatic run_card(input int rounds, input logic hc, input logic v1, input logic [15:0] ra);
        busy_rounds = rounds;
        cfg_hc  = hc;
        cfg_v1  = v1;
        cfg_rca = ra;
        exp_q.delete();
        rst_n  = 1'b0;
        cmd_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(!ready && !high_cap && !card_v1 && rca == 16'h0 && !cmd_oe, "R12", "reset state",
            64'({ready, high_cap, card_v1, cmd_oe, rca}), 64'd0);
        drive_expected();
        rst_n = 1'b1;
        serve_card();
        chk(high_cap == hc, "R7", "capacity flag", 64'(high_cap), 64'(hc));
        chk(card_v1 == v1, "R8", "version-1 flag", 64'(card_v1), 64'(v1));
        chk(rca == ra, "R9", "relative address", 64'(rca), 64'(ra));
        repeat (20) @(negedge clk);
        chk(ready == 1'b1 && !cmd_oe, "R10", "ready holds, bus quiet", 64'({ready, cmd_oe}), 64'(2'b10));
    endtask

    initial begin
        run_card(3, 1'b1, 1'b0, 16'h1234);
        run_card(1, 1'b0, 1'b1, 16'hBEEF);
        run_card(0, 1'b1, 1'b0, 16'h0001);
        run_card(2, 1'b0, 1'b0, 16'h8000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=complete");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule